// File: doc/BRIEF.md
# ATAPI Packet Phase Sequencer

This block runs the packet-command protocol behind an ATA task-file register port. When the host writes the packet opcode to the command register, the block enters command-out and gathers the next twelve bytes written to the data port. It then hands the packet to an external command interpreter over a one-cycle request with a registered payload. The interpreter answers with a transfer direction and a data-in length. The block does not carry the data bytes themselves. It sequences the data-in and completion phases, counts what the host drains through data-port reads, and raises an interrupt at each phase change.

While a packet command is active, the interrupt-reason bits take the place of the sector-count read value. The cylinder registers report the byte count of the current chunk, which is never larger than `MAX_CHUNK`. Longer transfers are split into several chunks, and each new chunk announces itself with its own interrupt. Data-out commands are not supported. They end in the completed phase with the abort error set.

Top module: `atapi_pkt_seq`

## Requirements
- R1: After reset the status register (address 7) reads 0x50 (ready and seek-complete, no DRQ, no error), `irq_o` is low, and the sector-count register (address 2) reads 0.
- R2: Writing 0xA0 to the command register (address 7) clears `irq_o` and the error register and enters command-out. No interrupt is raised. In that phase status reads 0x58 (DRQ is bit 3) and the interrupt reason reads 0x01.
- R3: In command-out, each data-port write (address 0) appends 1, 2 or 4 bytes for `host_size` 0, 1 or 2, lowest byte first. When the count reaches exactly 12, `cmd_req` pulses for one cycle with byte k on `cmd_pkt[8k+7:8k]`. Status then reads 0xD0 (busy is bit 7, DRQ clear) until the response arrives.
- R4: `cmd_len` is 10 when packet byte 0 is 0x25, 0x28 or 0x5A, and 12 for every other opcode.
- R5: A data-in response with a non-zero length enters data-in: the interrupt reason reads 0x02 and status reads 0x58. The chunk length is min(length, `MAX_CHUNK`), with its low byte on address 4 and its high byte on address 5. `irq_o` rises. A response of length zero enters completed instead: the interrupt reason reads 0x03, status reads 0x50, and `irq_o` rises.
- R6: The sector-count register returns the last value written to it when no packet command is active. While a packet command is active, it returns the phase's command/data bit in bit 0 and its direction bit in bit 1, with the upper bits zero.
- R7: Each data-port read in data-in reduces the chunk length by the access width (1, 2 or 4 bytes), saturating at zero, and adds the same amount to the received total.
- R8: When the chunk length reaches zero, one of two things happens, and `irq_o` rises in either case. If bytes are still outstanding, a new chunk of min(outstanding, `MAX_CHUNK`) begins. If none are outstanding, the phase becomes completed.
- R9: A data-out response sets the error register to 0x04 (abort), makes status read 0x51, enters completed and raises `irq_o`.
- R10: A status read clears `irq_o`. An error-register read (address 1) returns the error and clears it.
- R11: Writing any command code other than 0xA0 ends packet activity and clears DRQ. Data-port writes outside command-out do not reach the packet, and data-port reads outside data-in do not change any count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (used for read side effects) |
| host_addr | input | 3 | Task-file register index |
| host_size | input | 2 | Data-port access width: 0=1, 1=2, 2=4 bytes |
| host_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| irq_o | output | 1 | Interrupt request |
| cmd_req | output | 1 | One-cycle packet dispatch pulse |
| cmd_len | output | 4 | Effective packet length, 10 or 12 |
| cmd_pkt | output | 96 | Collected packet bytes |
| resp_valid | input | 1 | Interpreter response strobe |
| resp_dir_out | input | 1 | Response is a data-out command |
| resp_len | input | LEN_W | Data-in byte count of the response |

## Verification
The embedded properties check several rules on every cycle. The dispatch request lasts exactly one cycle. The packet opcode never raises an interrupt in the following cycle. The chunk length stays at or below the cap. A plain data read lowers the length by exactly the access width. A data-out response leaves the abort code behind. Other behaviours only show up in the bench's sweeps: the opcode-dependent packet length over all 256 opcodes, the packet byte order for all three access widths, and the chunk boundaries for every total up to 40 bytes against a 16-byte cap. The sweeps also cover the interrupt timing and the clear-on-read side effects.

// File: rtl/atapi_pkt_seq.sv
module atapi_pkt_seq #(
  parameter int MAX_CHUNK = 32768,
  parameter int LEN_W     = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [2:0]       host_addr,
  input  logic [1:0]       host_size,
  input  logic [31:0]      host_wdata,
  output logic [7:0]       host_rdata,
  output logic             irq_o,
  output logic             cmd_req,
  output logic [3:0]       cmd_len,
  output logic [95:0]      cmd_pkt,
  input  logic             resp_valid,
  input  logic             resp_dir_out,
  input  logic [LEN_W-1:0] resp_len
);
  localparam logic [7:0]       PKT_OP = 8'hA0;
  localparam logic [LEN_W-1:0] CAP    = LEN_W'(MAX_CHUNK);

  typedef enum logic [2:0] {PH_IDLE, PH_CMD, PH_WAIT, PH_DIN, PH_DONE} phase_t;

  phase_t           phase;
  logic [3:0]       nbytes;
  logic [7:0]       pkt [0:11];
  logic [7:0]       seccnt, err;
  logic             irq, req;
  logic [LEN_W-1:0] total, recv, rem;

  logic [2:0]       w;
  logic [4:0]       nsum;
  logic             cmd_wr, data_rd;
  logic [LEN_W-1:0] dec, rem_n, recv_n, left, nxt_chunk, resp_chunk;
  logic [1:0]       ireason;
  logic             drq, bsy;

  assign w       = (host_size == 2'd0) ? 3'd1 : (host_size == 2'd1) ? 3'd2 : 3'd4;
  assign nsum    = {1'b0, nbytes} + {2'b0, w};
  assign cmd_wr  = host_wr && host_addr == 3'd7;
  assign data_rd = host_rd && host_addr == 3'd0 && phase == PH_DIN && !cmd_wr;

  assign dec        = (LEN_W'(w) > rem) ? rem : LEN_W'(w);
  assign rem_n      = rem - dec;
  assign recv_n     = recv + dec;
  assign left       = total - recv_n;
  assign nxt_chunk  = (left > CAP) ? CAP : left;
  assign resp_chunk = (resp_len > CAP) ? CAP : resp_len;

  always_comb begin
    case (phase)
      PH_DIN:  ireason = 2'b10;
      PH_DONE: ireason = 2'b11;
      default: ireason = 2'b01;
    endcase
  end
  assign drq = (phase == PH_CMD) || (phase == PH_DIN);
  assign bsy = (phase == PH_WAIT);

  always_comb begin
    case (host_addr)
      3'd1:    host_rdata = err;
      3'd2:    host_rdata = (phase != PH_IDLE) ? {6'b0, ireason} : seccnt;
      3'd4:    host_rdata = rem[7:0];
      3'd5:    host_rdata = rem[15:8];
      3'd7:    host_rdata = {bsy, 3'b101, drq, 2'b00, err != 8'h00};
      default: host_rdata = 8'h00;
    endcase
  end

  always_comb begin
    for (int i = 0; i < 12; i++) cmd_pkt[8*i +: 8] = pkt[i];
  end
  assign cmd_len = (pkt[0] == 8'h25 || pkt[0] == 8'h28 || pkt[0] == 8'h5A) ? 4'd10 : 4'd12;
  assign cmd_req = req;
  assign irq_o   = irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      nbytes <= '0;
      seccnt <= '0;
      err    <= '0;
      irq    <= 1'b0;
      req    <= 1'b0;
      total  <= '0;
      recv   <= '0;
      rem    <= '0;
      for (int i = 0; i < 12; i++) pkt[i] <= '0;
    end else begin
      req <= 1'b0;
      if (host_rd && host_addr == 3'd7) irq <= 1'b0;
      if (host_rd && host_addr == 3'd1) err <= '0;
      if (host_wr) begin
        case (host_addr)
          3'd2: seccnt <= host_wdata[7:0];
          3'd7: begin
            irq    <= 1'b0;
            err    <= '0;
            nbytes <= '0;
            rem    <= '0;
            phase  <= (host_wdata[7:0] == PKT_OP) ? PH_CMD : PH_IDLE;
          end
          3'd0: if (phase == PH_CMD) begin
            for (int i = 0; i < 4; i++)
              if (3'(i) < w && ({1'b0, nbytes} + 5'(i)) < 5'd12)
                pkt[nbytes + 4'(i)] <= host_wdata[8*i +: 8];
            nbytes <= (nsum > 5'd12) ? 4'd12 : nsum[3:0];
            if (nsum >= 5'd12) begin
              phase <= PH_WAIT;
              req   <= 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (data_rd) begin
        rem  <= rem_n;
        recv <= recv_n;
        if (rem_n == '0) begin
          irq <= 1'b1;
          if (recv_n < total) rem <= nxt_chunk;
          else                phase <= PH_DONE;
        end
      end
      if (resp_valid && phase == PH_WAIT && !cmd_wr) begin
        irq <= 1'b1;
        if (resp_dir_out) begin
          err   <= 8'h04;
          phase <= PH_DONE;
        end else if (resp_len == '0) begin
          phase <= PH_DONE;
        end else begin
          phase <= PH_DIN;
          total <= resp_len;
          recv  <= '0;
          rem   <= resp_chunk;
        end
      end
    end
  end

  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req |=> !cmd_req);

  p_no_irq_on_pkt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && host_wdata[7:0] == PKT_OP) |=> !irq_o);

  p_chunk_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rem <= CAP);

  p_read_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !host_wr && rem > LEN_W'(w)) |=> rem == $past(rem) - LEN_W'($past(w)));

  p_dataout_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_dir_out && phase == PH_WAIT && !host_wr && !host_rd) |=> err == 8'h04);
endmodule

// File: tb/atapi_pkt_seq_tb.sv
`timescale 1ns/1ps
module atapi_pkt_seq_tb_top;
  localparam int MAXC = 16;
  localparam int LW   = 16;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0;
  logic [2:0] host_addr = 0;
  logic [1:0] host_size = 0;
  logic [31:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic irq_o, cmd_req;
  logic [3:0] cmd_len;
  logic [95:0] cmd_pkt;
  logic resp_valid = 0, resp_dir_out = 0;
  logic [LW-1:0] resp_len = 0;

  int checks = 0, errors = 0, cycles = 0, reqs = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  atapi_pkt_seq #(.MAX_CHUNK(MAXC), .LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq_o(irq_o), .cmd_req(cmd_req), .cmd_len(cmd_len),
    .cmd_pkt(cmd_pkt), .resp_valid(resp_valid), .resp_dir_out(resp_dir_out),
    .resp_len(resp_len));

  always @(posedge clk) begin
    cycles++;
    if (cmd_req) reqs++;
    if (cycles > 190000 && !done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input [2:0] a, input [31:0] d, input [1:0] sz);
    host_wr = 1; host_addr = a; host_wdata = d; host_size = sz;
    @(posedge clk); #1;
    host_wr = 0;
  endtask

  task automatic rd(input [2:0] a, input [1:0] sz, output logic [7:0] v);
    host_rd = 1; host_addr = a; host_size = sz;
    #1 v = host_rdata;
    @(posedge clk); #1;
    host_rd = 0;
  endtask

  task automatic respond(input bit dout, input int len);
    resp_valid = 1; resp_dir_out = dout; resp_len = LW'(len);
    @(posedge clk); #1;
    resp_valid = 0;
  endtask

  function automatic logic [7:0] pb(input logic [7:0] op, input int k);
    return (k == 0) ? op : 8'(int'(op) + k * 7);
  endfunction

  task automatic send_pkt(input logic [7:0] op, input logic [1:0] sz);
    int nb;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    for (int k = 0; k < 12; k += nb)
      wr(3'd0, {pb(op, k + 3), pb(op, k + 2), pb(op, k + 1), pb(op, k)}, sz);
  endtask

  initial begin
    logic [7:0] v;
    int r0;
    #12 rst_n = 1;
    @(posedge clk); #1;

    rd(3'd7, 0, v); chk(v == 8'h50, "R1 status", v, 8'h50);
    chk(irq_o == 0, "R1 irq", irq_o, 0);
    rd(3'd2, 0, v); chk(v == 8'h00, "R1 seccnt", v, 0);

    wr(3'd2, 32'h5A, 0);
    rd(3'd2, 0, v); chk(v == 8'h5A, "R6 idle seccnt", v, 8'h5A);
    r0 = reqs;
    wr(3'd0, 32'h11223344, 2);
    rd(3'd0, 0, v);
    chk(reqs == r0, "R11 idle data write", reqs, r0);
    rd(3'd4, 0, v); chk(v == 0, "R11 idle data read", v, 0);

    for (int op = 0; op < 256; op++) begin
      logic [1:0] sz;
      int el;
      sz = 2'(op % 3);
      wr(3'd7, 32'hA0, 0);
      chk(irq_o == 0, "R2 no irq", irq_o, 0);
      rd(3'd7, 0, v); chk(v == 8'h58, "R2 status", v, 8'h58);
      rd(3'd2, 0, v); chk(v == 8'h01, "R6 ireason cmd", v, 1);
      r0 = reqs;
      send_pkt(8'(op), sz);
      chk(cmd_req == 1, "R3 req", cmd_req, 1);
      for (int k = 0; k < 12; k++)
        chk(cmd_pkt[8*k +: 8] == pb(8'(op), k), "R3 byte", cmd_pkt[8*k +: 8], pb(8'(op), k));
      el = (op == 'h25 || op == 'h28 || op == 'h5A) ? 10 : 12;
      chk(cmd_len == 4'(el), "R4 len", cmd_len, el);
      rd(3'd7, 0, v); chk(v == 8'hD0, "R3 busy", v, 8'hD0);
      chk(reqs == r0 + 1, "R3 one pulse", reqs, r0 + 1);
      wr(3'd0, 32'hFF, 0);
      chk(reqs == r0 + 1, "R11 extra byte", reqs, r0 + 1);
      respond(0, 0);
      chk(irq_o == 1, "R5 zero irq", irq_o, 1);
      rd(3'd2, 0, v); chk(v == 8'h03, "R5 completed", v, 3);
      rd(3'd7, 0, v); chk(v == 8'h50, "R5 status done", v, 8'h50);
      chk(irq_o == 0, "R10 status clears irq", irq_o, 0);
    end

    for (int tot = 1; tot <= 40; tot++) begin
      for (int s = 0; s < 3; s++) begin
        int w, rem, recv, dec;
        bit ei;
        w = (s == 0) ? 1 : (s == 1) ? 2 : 4;
        wr(3'd7, 32'hA0, 0);
        send_pkt(8'h28, 2'(s));
        respond(0, tot);
        rem = (tot > MAXC) ? MAXC : tot; recv = 0;
        chk(irq_o == 1, "R5 irq", irq_o, 1);
        rd(3'd2, 0, v); chk(v == 8'h02, "R5 ireason din", v, 2);
        rd(3'd4, 0, v); chk(v == 8'(rem), "R5 cyl lo", v, rem);
        rd(3'd5, 0, v); chk(v == 8'(rem >> 8), "R5 cyl hi", v, rem >> 8);
        rd(3'd7, 0, v); chk(v == 8'h58, "R5 status din", v, 8'h58);
        while (recv < tot) begin
          rd(3'd0, 2'(s), v);
          dec = (w > rem) ? rem : w;
          rem -= dec; recv += dec; ei = 0;
          if (rem == 0) begin
            ei = 1;
            if (recv < tot) rem = (tot - recv > MAXC) ? MAXC : tot - recv;
          end
          chk(irq_o == ei, "R8 irq", irq_o, ei);
          rd(3'd4, 0, v); chk(v == 8'(rem), "R7 remaining", v, rem);
          if (ei) begin
            rd(3'd7, 0, v);
            chk(v == ((recv < tot) ? 8'h58 : 8'h50), "R8 phase status", v, (recv < tot) ? 'h58 : 'h50);
          end
        end
        rd(3'd2, 0, v); chk(v == 8'h03, "R8 completed", v, 3);
        rd(3'd0, 0, v);
        rd(3'd4, 0, v); chk(v == 0, "R11 read after done", v, 0);
      end
    end

    wr(3'd7, 32'hA0, 0);
    send_pkt(8'h2A, 0);
    respond(1, 8);
    chk(irq_o == 1, "R9 irq", irq_o, 1);
    rd(3'd2, 0, v); chk(v == 8'h03, "R9 completed", v, 3);
    wr(3'd7, 32'hA0, 0);
    chk(irq_o == 0, "R10 command clears irq", irq_o, 0);
    send_pkt(8'h2A, 1);
    respond(1, 8);
    rd(3'd7, 0, v); chk(v == 8'h51, "R9 status err", v, 8'h51);
    rd(3'd1, 0, v); chk(v == 8'h04, "R9 abort", v, 4);
    rd(3'd1, 0, v); chk(v == 8'h00, "R10 error cleared", v, 0);

    wr(3'd7, 32'hA0, 0);
    send_pkt(8'h28, 2);
    respond(0, 20);
    rd(3'd7, 0, v);
    r0 = reqs;
    wr(3'd0, 32'h01020304, 2);
    chk(reqs == r0, "R11 din data write", reqs, r0);
    rd(3'd4, 0, v); chk(v == 8'd16, "R11 din write no count", v, 16);
    wr(3'd7, 32'hEC, 0);
    rd(3'd2, 0, v); chk(v == 8'h5A, "R11 seccnt restored", v, 8'h5A);
    rd(3'd7, 0, v); chk(v == 8'h50, "R11 drq clear", v, 8'h50);
    rd(3'd0, 1, v);
    rd(3'd4, 0, v); chk(v == 0, "R11 idle read ignored", v, 0);
    chk(irq_o == 0, "R11 no irq", irq_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule